// File: doc/BRIEF.md
# Microprogram sequencer with bit-ORing

This block is the control unit of a single-bus processor, built as a microprogram. A microaddress register selects a word of a control store that is read without a clock. The encoded fields of that word are decoded into one enable line for each datapath control point: a bus source, a register or latch destination, an ALU function, memory read, clear-Y, carry-in, wait-for-memory and End. Each word also names the address of the word that follows it. Three sequencing flags change that address. One dispatches on the opcode. One ORs the source addressing-mode bits into bits 5..3. One ORs the indirect bit into bit 0. Together they let the routines for the five source modes of the add instruction share one operand-completion tail instead of each carrying its own copy.

The store holds the instruction fetch at 0..3, a conditional branch routine at octal 025..027, the source-mode routines for add at octal 101..165, and the shared completion at octal 170..173. A step that waits for memory holds the microaddress until `mfc` is high. A step that raises End always returns to address 0. Only the opcode field and the three source-mode bits of the instruction register are needed, so only those come in.

Top module: `ucode_seq`

## Requirements
- R1: A synchronous high `rst` puts the microaddress at 0. While reset is held, and in the first cycle after it, the outputs show the first fetch word: `pc_out`, `mar_in`, `mem_read`, `clear_y`, `carry_in`, `alu_add` and `z_in`, with every other output low.
- R2: The fetch continues as follows. Address 1 drives `z_out`, `pc_in` and `wait_mfc`. Address 2 drives `mdr_out` and `ir_in`. Address 3 drives no control output and dispatches.
- R3: A word with `wait_mfc` set repeats for as long as `mfc` is low. It moves on in the first cycle that follows a rising edge sampled with `mfc` high.
- R4: Dispatch uses `ir_op`. Code 4'b0001 (add) goes to octal 101 with the mode OR applied. Code 4'b0010 (branch) goes to octal 025, whatever `ir_mode` holds. Any other code goes back to address 0 and fetches again.
- R5: For add, the dispatch target is formed as follows. Bits 5..4 are ORed with `ir_mode[2:1]`, and bit 3 is ORed with the AND of all three `ir_mode` bits. This gives register mode 00x at octal 101, autoincrement 01x at 121, autodecrement 10x at 141 and indexed 110 at 161. Mode 111 lands on octal 171, which uses the instruction word still held in MDR as the operand.
- R6: The indirect OR puts `ir_mode[0]` into bit 0 of the target. A value of 0 inserts one extra memory indirection step (`mdr_out`, `mar_in`, `mem_read`, `wait_mfc`) at octal 170. A value of 1 skips that step. In register mode, 0 reads memory at Rsrc (`rsrc_out`, `mar_in`, `mem_read`, `wait_mfc`) and 1 copies Rsrc to Y (`rsrc_out`, `y_in`).
- R7: The shared completion runs as follows. Octal 171 drives `mdr_out` and `y_in`. Octal 172 drives `rdst_out`, `alu_add` and `z_in`. Octal 173 drives `z_out`, `rdst_in` and `end_op`.
- R8: After a word with `end_op` set, the next microaddress is 0, even when that word's next-address field points elsewhere.
- R9: The branch routine starts at octal 025 with `pc_out` and `y_in`. If `flag_n` is 0 it returns to address 0. Otherwise it continues with `offs_out`, `alu_add` and `z_in`, then `z_out`, `pc_in` and `end_op`.
- R10: Autoincrement first drives `rsrc_out`, `mar_in`, `mem_read`, `clear_y`, `carry_in`, `alu_add` and `z_in`. Autodecrement first drives `rsrc_out`, `clear_y`, `carry_in`, `alu_sub` and `z_in`, then `z_out`, `rsrc_in`, `mar_in` and `mem_read`. Autoincrement's second step is `z_out` with `rsrc_in`. Both modes then wait for memory with `wait_mfc` alone.
- R11: Indexed mode performs these steps in order. It fetches the index word the same way as fetch word 0, then drives `z_out`, `pc_in` and `wait_mfc`. Next come `mdr_out` with `y_in`, then `rsrc_out`, `alu_add` and `z_in`, then `z_out`, `mar_in`, `mem_read` and `wait_mfc`. It continues at octal 171.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_op | input | OP_W | Opcode field of the instruction register |
| ir_mode | input | 3 | Source addressing-mode bits of the instruction register |
| flag_n | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory function complete |
| pc_out | output | 1 | PC drives the bus |
| mdr_out | output | 1 | MDR drives the bus |
| z_out | output | 1 | Z drives the bus |
| rsrc_out | output | 1 | Source register drives the bus |
| rdst_out | output | 1 | Destination register drives the bus |
| offs_out | output | 1 | Instruction offset field drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| ir_in | output | 1 | IR loads from the bus |
| z_in | output | 1 | Z loads the ALU result |
| rsrc_in | output | 1 | Source register loads from the bus |
| rdst_in | output | 1 | Destination register loads from the bus |
| mar_in | output | 1 | MAR loads from the bus |
| mdr_in | output | 1 | MDR loads from the bus |
| tmp_in | output | 1 | TEMP loads from the bus |
| y_in | output | 1 | Y loads from the bus |
| alu_add | output | 1 | ALU adds |
| alu_sub | output | 1 | ALU subtracts |
| alu_xor | output | 1 | ALU exclusive-or |
| mem_read | output | 1 | Memory read request |
| wait_mfc | output | 1 | Step waits for memory completion |
| clear_y | output | 1 | Clear Y |
| carry_in | output | 1 | ALU carry-in |
| end_op | output | 1 | Last step of the instruction |

## Verification
The bench builds the block with its defaults, an 8-bit microaddress and a 4-bit opcode. The 8-bit width holds every octal label from 025 to 173, so each source routine, the bit-ORed dispatch targets and the shared tail at 170..173 can be reached. The 4-bit opcode leaves room for codes outside add and branch, which exercise the refetch path. All eight mode values are run, along with both outcomes of the branch test and a branch whose mode bits are all set. Timing corners are a memory stall held for several cycles and a reset that arrives in the middle of a routine.

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int UADDR_W = 8,
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] ir_op,
  input  logic [2:0]      ir_mode,
  input  logic            flag_n,
  input  logic            mfc,
  output logic            pc_out,
  output logic            mdr_out,
  output logic            z_out,
  output logic            rsrc_out,
  output logic            rdst_out,
  output logic            offs_out,
  output logic            pc_in,
  output logic            ir_in,
  output logic            z_in,
  output logic            rsrc_in,
  output logic            rdst_in,
  output logic            mar_in,
  output logic            mdr_in,
  output logic            tmp_in,
  output logic            y_in,
  output logic            alu_add,
  output logic            alu_sub,
  output logic            alu_xor,
  output logic            mem_read,
  output logic            wait_mfc,
  output logic            clear_y,
  output logic            carry_in,
  output logic            end_op
);

  localparam int P_SRC = UADDR_W;
  localparam int P_DST = UADDR_W + 3;
  localparam int P_D2  = UADDR_W + 6;
  localparam int P_ALU = UADDR_W + 9;
  localparam int P_FL  = UADDR_W + 14;
  localparam int W     = UADDR_W + 23;

  localparam logic [2:0] S_NO = 3'd0, S_PC = 3'd1, S_MDR = 3'd2, S_Z = 3'd3,
                         S_RS = 3'd4, S_RD = 3'd5, S_OFF = 3'd6;
  localparam logic [2:0] D_NO = 3'd0, D_PC = 3'd1, D_IR = 3'd2, D_Z = 3'd3,
                         D_RS = 3'd4, D_RD = 3'd5;
  localparam logic [2:0] E_NO = 3'd0, E_MAR = 3'd1, E_MDR = 3'd2, E_TMP = 3'd3,
                         E_Y = 3'd4;
  localparam logic [4:0] A_NO = 5'b0_0000, A_ADD = 5'b1_0000, A_SUB = 5'b1_0001,
                         A_XOR = 5'b1_1111;
  localparam logic [8:0] F_RD = 9'h001, F_WM = 9'h002, F_CLY = 9'h004,
                         F_CIN = 9'h008, F_END = 9'h010, F_DISP = 9'h020,
                         F_ORM = 9'h040, F_ORI = 9'h080, F_COND = 9'h100;
  localparam logic [OP_W-1:0] OP_ADD = OP_W'(1);
  localparam logic [OP_W-1:0] OP_BR  = OP_W'(2);

  function automatic logic [W-1:0] mw(input int nx, input logic [2:0] s,
                                      input logic [2:0] d, input logic [2:0] e,
                                      input logic [4:0] a, input logic [8:0] f);
    mw = {f, a, e, d, s, UADDR_W'(nx)};
  endfunction

  function automatic logic [W-1:0] ustore(input logic [UADDR_W-1:0] adr);
    case (int'(adr))
      0:     ustore = mw(1, S_PC, D_Z, E_MAR, A_ADD, F_RD | F_CLY | F_CIN);
      1:     ustore = mw(2, S_Z, D_PC, E_NO, A_NO, F_WM);
      2:     ustore = mw(3, S_MDR, D_IR, E_NO, A_NO, '0);
      3:     ustore = mw(0, S_NO, D_NO, E_NO, A_NO, F_DISP | F_ORM);
      'o025: ustore = mw(0, S_PC, D_NO, E_Y, A_NO, F_COND);
      'o026: ustore = mw('o027, S_OFF, D_Z, E_NO, A_ADD, '0);
      'o027: ustore = mw(0, S_Z, D_PC, E_NO, A_NO, F_END);
      'o101: ustore = mw('o102, S_NO, D_NO, E_NO, A_NO, F_ORI);
      'o102: ustore = mw('o171, S_RS, D_NO, E_MAR, A_NO, F_RD | F_WM);
      'o103: ustore = mw('o172, S_RS, D_NO, E_Y, A_NO, '0);
      'o121: ustore = mw('o122, S_RS, D_Z, E_MAR, A_ADD, F_RD | F_CLY | F_CIN);
      'o122: ustore = mw('o123, S_Z, D_RS, E_NO, A_NO, '0);
      'o123: ustore = mw('o170, S_NO, D_NO, E_NO, A_NO, F_WM | F_ORI);
      'o141: ustore = mw('o142, S_RS, D_Z, E_NO, A_SUB, F_CLY | F_CIN);
      'o142: ustore = mw('o143, S_Z, D_RS, E_MAR, A_NO, F_RD);
      'o143: ustore = mw('o170, S_NO, D_NO, E_NO, A_NO, F_WM | F_ORI);
      'o161: ustore = mw('o162, S_PC, D_Z, E_MAR, A_ADD, F_RD | F_CLY | F_CIN);
      'o162: ustore = mw('o163, S_Z, D_PC, E_NO, A_NO, F_WM);
      'o163: ustore = mw('o164, S_MDR, D_NO, E_Y, A_NO, '0);
      'o164: ustore = mw('o165, S_RS, D_Z, E_NO, A_ADD, '0);
      'o165: ustore = mw('o171, S_Z, D_NO, E_MAR, A_NO, F_RD | F_WM);
      'o170: ustore = mw('o171, S_MDR, D_NO, E_MAR, A_NO, F_RD | F_WM);
      'o171: ustore = mw('o172, S_MDR, D_NO, E_Y, A_NO, '0);
      'o172: ustore = mw('o173, S_RD, D_Z, E_NO, A_ADD, '0);
      'o173: ustore = mw('o174, S_Z, D_RD, E_NO, A_NO, F_END);
      default: ustore = '0;
    endcase
  endfunction

  logic [UADDR_W-1:0] upc, upc_nxt, nxt, dec_base, mode_or, tgt;
  logic [W-1:0] w;
  logic [2:0] src, dst, dst2;
  logic [3:0] alu;
  logic alu_en, f_disp, f_orm, f_ori, f_cond, dec_src, or_m;

  assign w      = ustore(upc);
  assign nxt    = w[UADDR_W-1:0];
  assign src    = w[P_SRC +: 3];
  assign dst    = w[P_DST +: 3];
  assign dst2   = w[P_D2 +: 3];
  assign alu    = w[P_ALU +: 4];
  assign alu_en = w[P_ALU + 4];
  assign {f_cond, f_ori, f_orm, f_disp, end_op, carry_in, clear_y, wait_mfc, mem_read} = w[P_FL +: 9];

  assign pc_out   = src == S_PC;
  assign mdr_out  = src == S_MDR;
  assign z_out    = src == S_Z;
  assign rsrc_out = src == S_RS;
  assign rdst_out = src == S_RD;
  assign offs_out = src == S_OFF;
  assign pc_in    = dst == D_PC;
  assign ir_in    = dst == D_IR;
  assign z_in     = dst == D_Z;
  assign rsrc_in  = dst == D_RS;
  assign rdst_in  = dst == D_RD;
  assign mar_in   = dst2 == E_MAR;
  assign mdr_in   = dst2 == E_MDR;
  assign tmp_in   = dst2 == E_TMP;
  assign y_in     = dst2 == E_Y;
  assign alu_add  = alu_en && alu == A_ADD[3:0];
  assign alu_sub  = alu_en && alu == A_SUB[3:0];
  assign alu_xor  = alu_en && alu == A_XOR[3:0];

  always_comb begin
    dec_base = '0;
    dec_src  = 1'b0;
    if (ir_op == OP_ADD) begin
      dec_base = UADDR_W'('o101);
      dec_src  = 1'b1;
    end else if (ir_op == OP_BR) begin
      dec_base = UADDR_W'('o025);
    end
  end

  assign mode_or = UADDR_W'({ir_mode[2:1], &ir_mode, 3'b000});
  assign or_m    = f_orm && (!f_disp || dec_src);
  assign tgt     = (f_disp ? dec_base : nxt)
                 | (or_m ? mode_or : '0)
                 | (f_ori ? UADDR_W'(ir_mode[0]) : '0);

  always_comb begin
    if (wait_mfc && !mfc)  upc_nxt = upc;
    else if (end_op)       upc_nxt = '0;
    else if (f_cond)       upc_nxt = flag_n ? upc + UADDR_W'(1) : nxt;
    else                   upc_nxt = tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upc_nxt;
  end

endmodule

// File: rtl/ucode_seq_props.sv
module ucode_seq_props #(
  parameter int UADDR_W = 8,
  parameter int OP_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [OP_W-1:0]    ir_op,
  input logic [2:0]         ir_mode,
  input logic               flag_n,
  input logic               mfc,
  input logic [UADDR_W-1:0] upc,
  input logic               wait_mfc,
  input logic               end_op,
  input logic               ir_in
);

  assert_reset_entry_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> upc == '0);

  assert_ir_then_dispatch_R2: assert property (@(posedge clk) disable iff (rst)
    ir_in |=> upc == UADDR_W'(3));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wait_mfc && !mfc) |=> $stable(upc));

  assert_mode_or_R5: assert property (@(posedge clk) disable iff (rst)
    (upc == UADDR_W'(3) && ir_op == OP_W'(1)) |=>
      (upc[5:4] == $past(ir_mode[2:1]) && upc[3] == &$past(ir_mode)));

  assert_end_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (end_op && !(wait_mfc && !mfc)) |=> upc == '0);

  assert_branch_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (upc == UADDR_W'('o025) && !flag_n) |=> upc == '0);

endmodule

bind ucode_seq ucode_seq_props #(.UADDR_W(UADDR_W), .OP_W(OP_W)) u_props (.*);

// File: tb/ucode_seq_test.sv
module ucode_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ir_op = '0;
  logic [2:0] ir_mode = '0;
  logic flag_n = 1'b0;
  logic mfc = 1'b1;
  logic pc_out, mdr_out, z_out, rsrc_out, rdst_out, offs_out, pc_in, ir_in, z_in;
  logic rsrc_in, rdst_in, mar_in, mdr_in, tmp_in, y_in, alu_add, alu_sub, alu_xor;
  logic mem_read, wait_mfc, clear_y, carry_in, end_op;
  logic [22:0] obs;
  logic [22:0] exp_q [0:15];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ucode_seq uut (.*);

  assign obs = {end_op, carry_in, clear_y, wait_mfc, mem_read, alu_xor, alu_sub, alu_add,
                y_in, tmp_in, mdr_in, mar_in, rdst_in, rsrc_in, z_in, ir_in, pc_in,
                offs_out, rdst_out, rsrc_out, z_out, mdr_out, pc_out};

  localparam logic [22:0] PCO = 23'd1 << 0, MDRO = 23'd1 << 1, ZO = 23'd1 << 2,
    RSO = 23'd1 << 3, RDO = 23'd1 << 4, OFO = 23'd1 << 5, PCI = 23'd1 << 6,
    IRI = 23'd1 << 7, ZI = 23'd1 << 8, RSI = 23'd1 << 9, RDI = 23'd1 << 10,
    MARI = 23'd1 << 11, YI = 23'd1 << 14, ADD = 23'd1 << 15, SUB = 23'd1 << 16,
    RD = 23'd1 << 18, WM = 23'd1 << 19, CLY = 23'd1 << 20, CIN = 23'd1 << 21,
    ENDB = 23'd1 << 22;
  localparam logic [22:0] F0 = PCO | MARI | RD | CLY | CIN | ADD | ZI;
  localparam logic [22:0] F1 = ZO | PCI | WM;
  localparam logic [22:0] F2 = MDRO | IRI;
  localparam logic [22:0] C170 = MDRO | MARI | RD | WM;
  localparam logic [22:0] C171 = MDRO | YI;
  localparam logic [22:0] C172 = RDO | ADD | ZI;
  localparam logic [22:0] C173 = ZO | RDI | ENDB;

  task automatic check_now(input logic [22:0] e, input string tag);
    n_checks++;
    if (obs !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, obs, e);
    end
  endtask

  task automatic check_seq(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      check_now(exp_q[i], $sformatf("%s step %0d", tag, i));
      @(negedge clk);
    end
  endtask

  task automatic put_fetch();
    exp_q[0] = F0; exp_q[1] = F1; exp_q[2] = F2; exp_q[3] = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_now(F0, "R1 held in reset");
    rst = 1'b0;
    check_now(F0, "R1 after release");
  endtask

  task automatic t_stall_unknown();
    ir_op = 4'h7; ir_mode = 3'b101;
    check_now(F0, "R2 fetch 0");
    @(negedge clk);
    mfc = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check_now(F1, "R3 stalled");
      @(negedge clk);
    end
    mfc = 1'b1;
    check_now(F1, "R3 release cycle");
    @(negedge clk);
    check_now(F2, "R2 IR load");
    @(negedge clk);
    check_now('0, "R2 dispatch step");
    @(negedge clk);
    check_now(F0, "R4 unknown opcode refetch");
  endtask

  task automatic t_add(input logic [2:0] m);
    int n;
    ir_op = 4'h1; ir_mode = m;
    put_fetch();
    n = 4;
    case (m)
      3'b000: begin exp_q[4] = '0; exp_q[5] = RSO | MARI | RD | WM; n = 6; end
      3'b001: begin exp_q[4] = '0; exp_q[5] = RSO | YI; n = 6; end
      3'b010, 3'b011: begin
        exp_q[4] = RSO | MARI | RD | CLY | CIN | ADD | ZI;
        exp_q[5] = ZO | RSI; exp_q[6] = WM; n = 7;
      end
      3'b100, 3'b101: begin
        exp_q[4] = RSO | CLY | CIN | SUB | ZI;
        exp_q[5] = ZO | RSI | MARI | RD; exp_q[6] = WM; n = 7;
      end
      3'b110: begin
        exp_q[4] = F0; exp_q[5] = F1; exp_q[6] = MDRO | YI;
        exp_q[7] = RSO | ADD | ZI; exp_q[8] = ZO | MARI | RD | WM; n = 9;
      end
      default: n = 4;
    endcase
    if (m[1] ^ m[2] && !m[0]) begin exp_q[n] = C170; n++; end
    if (m != 3'b001) begin exp_q[n] = C171; n++; end
    exp_q[n] = C172; exp_q[n+1] = C173; n += 2;
    check_seq(n, $sformatf("R5 R6 R7 R10 R11 add mode %b", m));
    check_now(F0, $sformatf("R8 restart after add mode %b", m));
  endtask

  task automatic t_branch(input logic n_flag);
    ir_op = 4'h2; ir_mode = 3'b111; flag_n = n_flag;
    put_fetch();
    exp_q[4] = PCO | YI;
    if (n_flag) begin
      exp_q[5] = OFO | ADD | ZI; exp_q[6] = ZO | PCI | ENDB;
      check_seq(7, "R4 R9 branch taken");
      check_now(F0, "R8 restart after branch");
    end else begin
      check_seq(5, "R4 R9 branch not taken");
      check_now(F0, "R9 exit to fetch on N=0");
    end
    flag_n = 1'b0;
  endtask

  task automatic t_reset_mid();
    ir_op = 4'h1; ir_mode = 3'b011;
    put_fetch();
    exp_q[4] = RSO | MARI | RD | CLY | CIN | ADD | ZI;
    check_seq(5, "R10 autoincrement start");
    rst = 1'b1;
    @(negedge clk);
    check_now(F0, "R1 reset mid routine");
    rst = 1'b0;
    check_now(F0, "R1 released mid routine");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, all requirements");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_stall_unknown();
    for (int m = 0; m < 8; m++) t_add(3'(m));
    t_branch(1'b1);
    t_branch(1'b0);
    t_reset_mid();
    t_add(3'b111);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule